// File: doc/BRIEF.md
# Multiplexed-Bus Program ROM Emulator

This block stands in for a bank of small program-ROM chips sitting on a 4-bit time-multiplexed processor bus. Each instruction cycle has eight subcycles. The processor sends a 12-bit instruction address one nibble at a time during the first three subcycles. It then expects the addressed program byte back, as two nibbles, during the two memory subcycles that follow. A sync strobe from the processor marks where each cycle starts.

The block holds one emulator instance for each chip. All instances share one external synchronous memory through a 12-bit address bus and an 8-bit data bus. The address bus is wired-OR: an instance that is not selected outputs all zeros, so the bus reads zero when nobody drives it. The memory must register its read address on the clock edge at which `rom_rd_en` is high. It must then hold that byte on `rom_data` until the next read, which gives one clock of latency.

A power-on-clear input resets the block. It takes effect at once and is released on a clock edge. The block drives nothing until it has seen a sync strobe after reset.

Top module: `mbus_rom_array`

## Requirements
- R1: While `poc` is high, `data_oe`, `rom_rd_en`, `addr_drv` and `rom_addr` are all zero, and they fall to zero as soon as `poc` rises, without waiting for a clock edge. After `poc` is released, nothing is driven until a sync strobe has been seen.
- R2: A clock cycle in which `sync` is high is followed by subcycle A1. After that, one subcycle passes per clock in the order A1, A2, A3, M1, M2, X1, X2, X3, and the order then repeats.
- R3: The address is taken from `data_in` low nibble first: A1 carries bits 3:0, A2 carries bits 7:4 and A3 carries bits 11:8.
- R4: During A3, only the instance whose chip number (CHIP_BASE + index, 0 to 4 by default) equals bits 11:8 drives the address. That instance puts the full 12-bit address on `rom_addr`, raises `rom_rd_en`, and sets bit index of `addr_drv`. At most one `addr_drv` bit is ever high.
- R5: When no instance is selected, `rom_addr` is all zeros and `rom_rd_en` is low. This covers every subcycle other than A3, and A3 when bits 11:8 name no chip.
- R6: When the instance was selected in the preceding A3, `data_oe` is high and `data_out` = `rom_data[7:4]` in M1. In M2, `data_oe` is high and `data_out` = `rom_data[3:0]`.
- R7: `data_oe` is low and `data_out` is zero in A1, A2, A3, X1, X2 and X3, and in M1 and M2 of any cycle whose address named no chip.
- R8: Values on `data_in` during M1, M2, X1, X2 and X3 have no effect: the bus outputs stay zero in those subcycles, except for the ROM nibbles set out in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subcycle clock, one edge per subcycle |
| poc | input | 1 | Power-on clear, active high, takes effect at once |
| sync | input | 1 | High in the last subcycle before A1 |
| data_in | input | 4 | Processor data bus as seen by the ROMs |
| data_out | output | 4 | Nibble returned to the processor (zero when not driving) |
| data_oe | output | 1 | Drive enable for `data_out` onto the processor bus |
| rom_addr | output | 12 | Wired-OR address to the shared memory |
| rom_rd_en | output | 1 | Read strobe to the shared memory |
| rom_data | input | 8 | Byte from the shared memory, one clock after the read |
| addr_drv | output | NUM_CHIPS | Per-instance address-bus drive enables |

## Verification
Addresses whose high nibble names each mapped chip are compared with addresses that name an unmapped chip. This separates correct chip decoding and returned nibbles from a bus that stays silent and zero. Random values on `data_in` during the memory and execution subcycles, including values that look like chip numbers, show that only the three address subcycles are sampled. The directed addresses 0x000, 0x4FF, 0x500 and 0xFFF cover the edges of the decoded chip range. Two reset patterns are used: `poc` raised in the middle of an M1 drive, and idle clocks with no sync after release. These show that the clear takes effect without a clock and that tracking waits for the strobe.

// File: rtl/mbus_rom_pkg.sv
package mbus_rom_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    PH_A1, PH_A2, PH_A3, PH_M1, PH_M2, PH_X1, PH_X2, PH_X3
  } phase_e;
endpackage

// File: rtl/mbus_phase_tracker.sv
module mbus_phase_tracker
  import mbus_rom_pkg::*;
(
  input  logic   clk,
  input  logic   poc,
  input  logic   sync,
  output logic   rst,
  output phase_e phase,
  output logic   run
);
  // clear is set at once, released on a clock edge
  always_ff @(posedge clk or posedge poc) begin
    if (poc) rst <= 1'b1;
    else     rst <= 1'b0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= PH_X3;
      run   <= 1'b0;
    end else if (sync) begin
      phase <= PH_A1;
      run   <= 1'b1;
    end else if (run) begin
      phase <= phase_e'(phase + 3'd1);
    end
  end

  assert_sync_to_a1_R2: assert property (@(posedge clk) disable iff (rst || poc)
    sync |=> (phase == PH_A1 && run));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst || poc)
    (run && !sync) |=> (3'(phase) == 3'($past(phase)) + 3'd1));
endmodule

// File: rtl/mbus_rom_chip.sv
module mbus_rom_chip
  import mbus_rom_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int CHIP_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  phase_e            phase,
  input  logic [NIB_W-1:0]  data_in,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rd_en,
  output logic              drv,
  output logic [NIB_W-1:0]  data_out,
  output logic              data_oe
);
  localparam int LO_W = ADDR_W - NIB_W;

  logic [NIB_W-1:0] lo_q, mid_q;
  logic             sel_q;
  logic             sel_now;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lo_q  <= '0;
      mid_q <= '0;
      sel_q <= 1'b0;
    end else if (run) begin
      if (phase == PH_A1) lo_q  <= data_in;
      if (phase == PH_A2) mid_q <= data_in;
      if (phase == PH_A3) sel_q <= sel_now;
    end
  end

  // read launched in A3 so the byte is back by M1
  assign sel_now  = run && (phase == PH_A3) && (data_in == NIB_W'(CHIP_ID));
  assign drv      = sel_now;
  assign rd_en    = sel_now;
  assign rom_addr = sel_now ? {data_in, LO_W'({mid_q, lo_q})} : '0;

  always_comb begin
    data_oe  = 1'b0;
    data_out = '0;
    if (run && sel_q) begin
      if (phase == PH_M1) begin
        data_oe  = 1'b1;
        data_out = rom_data[DATA_W-1 -: NIB_W];
      end else if (phase == PH_M2) begin
        data_oe  = 1'b1;
        data_out = rom_data[NIB_W-1:0];
      end
    end
  end

  assert_drive_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> $past(rd_en));
endmodule

// File: rtl/mbus_rom_array.sv
module mbus_rom_array
  import mbus_rom_pkg::*;
#(
  parameter int NUM_CHIPS = 5,
  parameter int CHIP_BASE = 0,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 poc,
  input  logic                 sync,
  input  logic [NIB_W-1:0]     data_in,
  output logic [NIB_W-1:0]     data_out,
  output logic                 data_oe,
  output logic [ADDR_W-1:0]    rom_addr,
  output logic                 rom_rd_en,
  input  logic [DATA_W-1:0]    rom_data,
  output logic [NUM_CHIPS-1:0] addr_drv
);
  logic   rst;
  logic   run;
  phase_e phase;

  logic [ADDR_W-1:0] c_addr [NUM_CHIPS];
  logic [NIB_W-1:0]  c_dout [NUM_CHIPS];
  logic [NUM_CHIPS-1:0] c_rd, c_oe;

  mbus_phase_tracker u_track (
    .clk(clk), .poc(poc), .sync(sync),
    .rst(rst), .phase(phase), .run(run)
  );

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
    mbus_rom_chip #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_ID(CHIP_BASE + i)
    ) u_chip (
      .clk(clk), .rst(rst), .run(run), .phase(phase),
      .data_in(data_in), .rom_data(rom_data),
      .rom_addr(c_addr[i]), .rd_en(c_rd[i]), .drv(addr_drv[i]),
      .data_out(c_dout[i]), .data_oe(c_oe[i])
    );
  end

  // wired-OR: idle instances contribute zeros
  always_comb begin
    rom_addr = '0;
    data_out = '0;
    for (int i = 0; i < NUM_CHIPS; i++) begin
      rom_addr = rom_addr | c_addr[i];
      data_out = data_out | c_dout[i];
    end
  end

  assign rom_rd_en = |c_rd;
  assign data_oe   = |c_oe;

  assert_one_driver_R4: assert property (@(posedge clk) disable iff (rst || poc)
    $onehot0(addr_drv));

  assert_idle_bus_zero_R5: assert property (@(posedge clk) disable iff (rst || poc)
    (addr_drv == '0) |-> (rom_addr == '0 && !rom_rd_en));

  assert_two_nibbles_R6: assert property (@(posedge clk) disable iff (rst || poc)
    $rose(data_oe) |=> data_oe);

  assert_drive_ends_R7: assert property (@(posedge clk) disable iff (rst || poc)
    (data_oe && $past(data_oe)) |=> !data_oe);

  assert_quiet_data_R7: assert property (@(posedge clk) disable iff (rst || poc)
    !data_oe |-> (data_out == '0));
endmodule

// File: tb/mbus_rom_array_test.sv
`timescale 1ns/1ps
module mbus_rom_array_test;
  localparam int NUM = 5;

  logic clk = 1'b0;
  logic poc, sync;
  logic [3:0] data_in;
  logic [3:0] data_out;
  logic data_oe;
  logic [11:0] rom_addr;
  logic rom_rd_en;
  logic [7:0] rom_data = 8'h00;
  logic [NUM-1:0] addr_drv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbus_rom_array uut (
    .clk(clk), .poc(poc), .sync(sync), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .rom_addr(rom_addr),
    .rom_rd_en(rom_rd_en), .rom_data(rom_data), .addr_drv(addr_drv)
  );

  function automatic logic [7:0] pat(input logic [11:0] a);
    int v;
    v = (int'(a) * 53) ^ (int'(a) >> 3) ^ 32'h5A;
    return v[7:0];
  endfunction

  // shared synchronous memory model, one clock of latency
  always @(posedge clk) if (rom_rd_en) rom_data <= pat(rom_addr);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    check(req, "data_oe", 32'(data_oe), 0);
    check(req, "data_out", 32'(data_out), 0);
    check(req, "rom_addr", 32'(rom_addr), 0);
    check(req, "rom_rd_en", 32'(rom_rd_en), 0);
    check(req, "addr_drv", 32'(addr_drv), 0);
  endtask

  // enter just after the X3 slot with sync already high
  task automatic run_cycle(input logic [11:0] a, input bit abort);
    bit hit;
    logic [7:0] b;
    hit = (a[11:8] < 4'(NUM));
    b = pat(a);
    @(negedge clk); sync = 0; data_in = a[3:0]; #1;
    idle_outputs("R5");                               // A1
    @(negedge clk); data_in = a[7:4]; #1;
    idle_outputs("R7");                               // A2
    @(negedge clk); data_in = a[11:8]; #1;            // A3
    check("R4", "rom_addr", 32'(rom_addr), hit ? 32'(a) : 0);
    check("R3", "rd_en", 32'(rom_rd_en), 32'(hit));
    check("R4", "addr_drv", 32'(addr_drv), hit ? (32'd1 << a[11:8]) : 0);
    check("R7", "oe in A3", 32'(data_oe), 0);
    @(negedge clk); data_in = 4'($urandom); #1;       // M1
    check("R6", "oe M1", 32'(data_oe), 32'(hit));
    check("R6", "nibble M1", 32'(data_out), hit ? 32'(b[7:4]) : 0);
    check("R8", "addr M1", 32'(rom_addr), 0);
    if (abort) begin
      poc = 1; #1;
      idle_outputs("R1");
      @(negedge clk); poc = 0; data_in = 4'($urandom); #1;
      idle_outputs("R1");
      @(negedge clk); data_in = 4'($urandom); #1;
      idle_outputs("R1");
      sync = 1;
      return;
    end
    @(negedge clk); data_in = 4'($urandom); #1;       // M2
    check("R6", "oe M2", 32'(data_oe), 32'(hit));
    check("R6", "nibble M2", 32'(data_out), hit ? 32'(b[3:0]) : 0);
    for (int s = 0; s < 3; s++) begin                 // X1..X3
      @(negedge clk); data_in = 4'($urandom % NUM);
      if (s == 2) sync = 1;
      #1;
      idle_outputs("R8");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    poc = 1; sync = 0; data_in = 4'h0;
    #1;
    idle_outputs("R1");
    repeat (3) @(negedge clk);
    idle_outputs("R1");
    poc = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); data_in = 4'($urandom); #1;
      idle_outputs("R1");
    end
    sync = 1;
    run_cycle(12'h000, 0);
    run_cycle(12'h4FF, 0);
    run_cycle(12'h500, 0);
    run_cycle(12'hFFF, 0);
    for (int c = 0; c < NUM; c++) run_cycle({4'(c), 8'($urandom)}, 0);
    run_cycle(12'h2A7, 1);
    run_cycle(12'h3C1, 0);
    for (int k = 0; k < 300; k++) run_cycle(12'($urandom), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule